// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a microcontroller timer. It watches a free-running counter that is shared with other channels and runs in one of two modes. As an input-capture channel it copies the counter into its 16-bit value register when the selected edge appears on its pin. As an output-compare channel it raises an event when the counter reaches the value register, and it can toggle, clear or set its output pin at that moment.

Software reaches the channel through a byte-wide register bus with three locations:

| Address | Contents |
|---|---|
| 0 | Status/control byte |
| 1 | High byte of the value register |
| 2 | Low byte of the value register |

Each event sets a sticky flag. The interrupt line is the flag ANDed with an enable bit. The flag can only be cleared by a two-step handshake: read the status byte while the flag is set, then write a zero to the flag bit. A new event that arrives between those two steps cancels the handshake, so a request is never dropped.

Top module: `tmr_chan_ctrl`

## Requirements
- R1: After reset, every status/control bit reads 0, `irq` is 0 and `pin_out` is 0.
- R2: Address 0 holds the status/control byte, with these fields:
  - bit 7: event flag.
  - bit 6: interrupt enable.
  - bit 5: mode B.
  - bit 4: mode A, where 0 selects capture and 1 selects compare.
  - bits 3:2: edge/action select.
  - bit 1: overflow-toggle bit, stored only.
  - bit 0: full-duty bit, stored only.

  Bits 6 to 0 are written and read back unchanged.
- R3: With `HAS_MODE_B` = 0, bit 5 reads 0 and writes to it are ignored.
- R4: In capture mode the edge/action select chooses the active edge: 01 rising, 10 falling, 11 both, 00 none. An active edge on `pin_in` sets the flag on the third rising clock edge after the pin changes. An inactive edge sets nothing.
- R5: The capture loads the value register with `cnt` on the clock edge that sets the flag. The value then reads back on address 1 (high byte) and address 2 (low byte). A register write is also stored there.
- R6: In compare mode the flag sets on the clock edge at which `cnt` first equals the value register. Staying equal on later cycles gives no further event.
- R7: On each compare event the edge/action select drives `pin_out`: 01 toggle, 10 clear, 11 set, 00 no change. Outside compare events `pin_out` does not change.
- R8: `irq` equals the flag ANDed with the interrupt enable, in the same cycle.
- R9: Reading address 0 while the flag is set arms the clear. A following write to address 0 with bit 7 = 0 then clears the flag.
- R10: A write of 1 to bit 7 has no effect on the flag. A write of 0 without an armed read also leaves the flag set.
- R11: An event between the arming read and the zero write keeps the flag set after that write. If it is a capture, it also reloads the value register.
- R12: A write to address 0 with bit 7 = 1 cancels an armed clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe; `rdata` is valid one cycle later |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cnt | input | 16 | Shared free-running counter value |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_out | output | 1 | Registered compare output pin |
| irq | output | 1 | Interrupt request, registered |

## Verification
Each result has a fixed latency, and every check samples at that cycle:

| Result | Due |
|---|---|
| Pin edge to flag and `irq` | Third rising edge after the pin changes (two synchronizer flops, then the edge-detect flop) |
| Compare match to flag, `irq` and `pin_out` | The edge at which `cnt` first equals the value |
| Register read | `rdata` on the edge that takes `rd_en` |

The bench drives every input on the falling clock edge and samples outputs on a later falling edge. For a pin edge it checks `irq` both at the second and at the third falling edge, so the exact cycle is pinned down. The counter is held still around each capture, so the expected captured value is unambiguous.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_VHI  = 2'd1;
  localparam logic [ADDR_W-1:0] A_VLO  = 2'd2;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_MODB = 5;
  localparam int B_MODA = 4;
  localparam int B_SELH = 3;
  localparam int B_SELL = 2;
  localparam int B_OVT  = 1;
  localparam int B_FULL = 0;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wr_flag_bit,
  output logic flag_q,
  output logic flag_nxt,
  output logic armed_q
);
  logic armed_nxt;

  always_comb begin
    armed_nxt = armed_q;
    if (evt)                    armed_nxt = 1'b0;
    else if (wr_stat)           armed_nxt = 1'b0;
    else if (rd_stat && flag_q) armed_nxt = 1'b1;

    flag_nxt = flag_q;
    if (evt)                                      flag_nxt = 1'b1;
    else if (wr_stat && !wr_flag_bit && armed_q)  flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_nxt;
      armed_q <= armed_nxt;
    end
  end
endmodule

// File: rtl/tmr_pin_drive.sv
module tmr_pin_drive
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [1:0] act,
  output logic       pin_q
);
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else if (fire) begin
      unique case (pin_act_e'(act))
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_CLEAR:  pin_q <= 1'b0;
        ACT_SET:    pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_MODE_B = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              irq
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic             ie_q, modb_q, moda_q, ovt_q, full_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] value_q;
  logic             match_q;
  logic             rise, fall;
  logic             evt_cap, evt_cmp, evt;
  logic             flag_q, flag_nxt, armed_q;
  logic             rd_stat, wr_stat;
  logic             ie_nxt;
  logic [BYTE_W-1:0] stat_rd;

  assign rd_stat = rd_en && (addr == A_STAT);
  assign wr_stat = wr_en && (addr == A_STAT);

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_in), .rise(rise), .fall(fall)
  );

  assign evt_cap = !moda_q && ((sel_q[0] && rise) || (sel_q[1] && fall));
  assign evt_cmp = moda_q && (cnt == value_q) && !match_q;
  assign evt     = evt_cap || evt_cmp;

  tmr_flag_ctl u_flag (
    .clk(clk), .rst(rst), .evt(evt), .rd_stat(rd_stat), .wr_stat(wr_stat),
    .wr_flag_bit(wdata[B_FLAG]), .flag_q(flag_q), .flag_nxt(flag_nxt),
    .armed_q(armed_q)
  );

  tmr_pin_drive u_drive (
    .clk(clk), .rst(rst), .fire(evt_cmp), .act(sel_q), .pin_q(pin_out)
  );

  assign ie_nxt = wr_stat ? wdata[B_IE] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      modb_q <= 1'b0;
      moda_q <= 1'b0;
      sel_q  <= 2'b00;
      ovt_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (wr_stat) begin
      ie_q   <= wdata[B_IE];
      moda_q <= wdata[B_MODA];
      sel_q  <= wdata[B_SELH:B_SELL];
      ovt_q  <= wdata[B_OVT];
      full_q <= wdata[B_FULL];
      if (HAS_MODE_B) modb_q <= wdata[B_MODB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= (cnt == value_q);
      if (evt_cap) value_q <= cnt;
      else if (wr_en && addr == A_VHI) value_q[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
      else if (wr_en && addr == A_VLO) value_q[BYTE_W-1:0] <= wdata;
    end
  end

  assign stat_rd = {flag_q, ie_q, modb_q, moda_q, sel_q, ovt_q, full_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= flag_nxt && ie_nxt;
      if (rd_en) begin
        unique case (addr)
          A_STAT:  rdata <= stat_rd;
          A_VHI:   rdata <= BYTE_W'(value_q >> BYTE_W);
          A_VLO:   rdata <= value_q[BYTE_W-1:0];
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_chan_ctrl_chk.sv
module tmr_chan_ctrl_chk #(
  parameter int CNT_W      = 16,
  parameter bit HAS_MODE_B = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       addr,
  input logic             rd_en,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       stat_rd,
  input logic             irq,
  input logic             pin_out,
  input logic             evt,
  input logic             armed_q,
  input logic [CNT_W-1:0] value_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stat_rd == 8'h00 && !irq && !pin_out)); // R1

  AST_MODE_B_ZERO: assert property (@(posedge clk) disable iff (rst)
    (HAS_MODE_B == 1'b0) |-> !stat_rd[5]); // R3

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (evt && !stat_rd[4]) |=> (value_q == $past(cnt))); // R5

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt |=> stat_rd[7]); // R6

  AST_PIN_ON_COMPARE: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_out) |-> $past(evt && stat_rd[4])); // R7

  AST_IRQ_IS_AND: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_rd[7] && stat_rd[6])); // R8

  AST_ARM_BY_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(rd_en && addr == 2'd0 && stat_rd[7])); // R9

  AST_CLEAR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_rd[7]) |-> $past(wr_en && addr == 2'd0 && !wdata[7] && armed_q)); // R10
endmodule

bind tmr_chan_ctrl tmr_chan_ctrl_chk #(.CNT_W(CNT_W), .HAS_MODE_B(HAS_MODE_B)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .cnt(cnt), .stat_rd(stat_rd), .irq(irq), .pin_out(pin_out),
  .evt(evt), .armed_q(armed_q), .value_q(value_q)
);

// File: tb/test_tmr_chan_ctrl.sv
module test_tmr_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, rdata_l;
  logic [15:0] cnt = 16'h1234;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_out_l, irq, irq_l;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  tmr_chan_ctrl i_tmr_chan_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cnt(cnt), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  tmr_chan_ctrl #(.HAS_MODE_B(1'b0)) i_tmr_chan_ctrl_lite (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata_l), .cnt(cnt), .pin_in(pin_in),
    .pin_out(pin_out_l), .irq(irq_l)
  );

  // {value written to status, value expected back}
  localparam logic [15:0] REG_VEC [4] = '{16'hFF7F, 16'h5555, 16'h2A2A, 16'h0000};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    bus_rd(2'd0, rv);
    check("R1", {8'h0, rv}, 16'h0000);
    check("R1", {14'h0, irq, pin_out}, 16'h0000);

    // R2 / R3 / R10 status byte readback table
    for (int i = 0; i < 4; i++) begin
      bus_wr(2'd0, REG_VEC[i][15:8]);
      bus_rd(2'd0, rv);
      check("R2_R10", {8'h0, rv}, {8'h0, REG_VEC[i][7:0]});
      check("R3", {8'h0, rdata_l}, {8'h0, REG_VEC[i][7:0] & 8'hDF});
    end

    // R4 / R5 rising-edge capture with latency
    bus_wr(2'd0, 8'h44);
    cnt = 16'hABCD;
    tick(2);
    pin_in = 1'b1;
    tick(2);
    check("R4", {15'h0, irq}, 16'h0);
    tick(1);
    check("R4_R8", {15'h0, irq}, 16'h1);
    bus_rd(2'd0, rv);
    check("R4", {8'h0, rv}, 16'h00C4);
    bus_rd(2'd1, rv);
    check("R5", {8'h0, rv}, 16'h00AB);
    bus_rd(2'd2, rv);
    check("R5", {8'h0, rv}, 16'h00CD);
    // R9 armed clear
    bus_wr(2'd0, 8'h44);
    bus_rd(2'd0, rv);
    check("R9", {8'h0, rv}, 16'h0044);
    check("R9_R8", {15'h0, irq}, 16'h0);

    // R4 falling edge ignored under rising select
    pin_in = 1'b0;
    tick(5);
    bus_rd(2'd0, rv);
    check("R4", {8'h0, rv}, 16'h0044);

    // R4 falling select: rise ignored, fall captures
    bus_wr(2'd0, 8'h48);
    cnt = 16'h0777;
    pin_in = 1'b1;
    tick(5);
    check("R4", {15'h0, irq}, 16'h0);
    pin_in = 1'b0;
    tick(5);
    check("R4", {15'h0, irq}, 16'h1);

    // R10 zero write without armed read
    bus_wr(2'd0, 8'h48);
    tick(1);
    check("R10", {15'h0, irq}, 16'h1);

    // R12 write of bit7=1 cancels arming
    bus_rd(2'd0, rv);
    check("R12", {8'h0, rv}, 16'h00C8);
    bus_wr(2'd0, 8'hC8);
    bus_wr(2'd0, 8'h48);
    bus_rd(2'd0, rv);
    check("R12", {8'h0, rv}, 16'h00C8);

    // R11 event between arming read and zero write
    pin_in = 1'b1;
    tick(5);
    bus_rd(2'd0, rv);
    cnt = 16'h1111;
    pin_in = 1'b0;
    tick(5);
    bus_wr(2'd0, 8'h48);
    bus_rd(2'd0, rv);
    check("R11", {8'h0, rv}, 16'h00C8);
    bus_rd(2'd2, rv);
    check("R11", {8'h0, rv}, 16'h0011);
    bus_rd(2'd0, rv);
    bus_wr(2'd0, 8'h48);
    check("R9", {15'h0, irq}, 16'h0);

    // R6 / R7 compare mode
    cnt = 16'h0000;
    bus_wr(2'd1, 8'h20);
    bus_wr(2'd2, 8'h10);
    bus_wr(2'd0, 8'h54);
    tick(1);
    check("R7", {15'h0, pin_out}, 16'h0);
    cnt = 16'h2010;
    tick(1);
    check("R6", {15'h0, irq}, 16'h1);
    check("R7", {15'h0, pin_out}, 16'h1);
    tick(3);
    check("R6", {15'h0, pin_out}, 16'h1);
    cnt = 16'h2011;
    bus_wr(2'd0, 8'h58);
    cnt = 16'h2010;
    tick(1);
    check("R7", {15'h0, pin_out}, 16'h0);
    cnt = 16'h2011;
    bus_wr(2'd0, 8'h5C);
    cnt = 16'h2010;
    tick(1);
    check("R7", {15'h0, pin_out}, 16'h1);
    cnt = 16'h2011;
    bus_rd(2'd0, rv);
    bus_wr(2'd0, 8'h50);
    bus_rd(2'd0, rv);
    check("R9", {8'h0, rv}, 16'h0050);
    cnt = 16'h2010;
    tick(1);
    bus_rd(2'd0, rv);
    check("R6", {8'h0, rv}, 16'h00D0);
    check("R7", {15'h0, pin_out}, 16'h1);
    cnt = 16'h2011;
    bus_wr(2'd0, 8'h54);
    cnt = 16'h2010;
    tick(1);
    check("R7", {15'h0, pin_out}, 16'h0);

    // R1 reset again clears everything
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    bus_rd(2'd0, rv);
    check("R1", {8'h0, rv}, 16'h0000);
    check("R1", {14'h0, irq, pin_out}, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule